// File: doc/BRIEF.md
# Audio Transmit FIFO with DMA Request Generation

This block sits between a DMA engine and the output shift register of an audio serial transmitter. It keeps an eight-entry buffer of stereo PCM words and raises DMA write requests so that the engine keeps the buffer topped up. Each entry is a 32-bit stereo word. The left sample sits in the upper half and the right sample in the lower half. When the serializer asks for its next word, the head entry moves into a registered output.

After enable, nothing is released to the serializer until the buffer has been completely full once. From then on, every entry that leaves frees a slot, and a request is raised again. Requests continue until the buffer is full once more. A mode input chooses between two request schemes. In the first, a single line asks for packed stereo words. In the second, separate left and right lines ask for 16-bit samples, which must arrive left first and then right, and are paired into one entry. A load request made while the buffer is empty after output has begun returns silence and sets a sticky underrun flag. The flag is cleared by a write-one-to-clear pulse. Dropping the enable input flushes everything.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, req_l, req_r and underrun are 0 and ld_data is 0.
- R2: The buffer holds at most DEPTH (8) entries and returns them in write order. A write accepted while the buffer is full is discarded and never reaches ld_data.
- R3: With split_mode = 0, each accepted write is one entry, with the left sample in wr_data[31:16] and the right sample in wr_data[15:0]. req_r stays 0, and req_l is 1 while the block is enabled and the buffer is not full.
- R4: Until the buffer has been full once since enable, ld_req removes no entry, leaves ld_data at 0 and does not set underrun.
- R5: A request line falls in the cycle after the write that fills the buffer. It rises again in the cycle after a load that frees an entry.
- R6: With split_mode = 1, the sample is wr_data[15:0]. The first write after enable is the left sample and the next is the right sample, and the pair is stored as {left, right}. req_l is 1 when a left sample is expected and the buffer is not full. req_r is 1 when a right sample is expected and the buffer is not full. The two lines are never both 1.
- R7: A ld_req while output has started and the buffer is empty sets ld_data to 0 and sets underrun. underrun stays 1 until a cycle with underrun_clr = 1.
- R8: While enable is 0, the entries, pointers, prefill state and left/right pairing are cleared, and both request lines are 0 from the next clock edge.
- R9: After prefill, a ld_req with entries present shows the head entry on ld_data from the next clock edge. The value is held until the next ld_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 flushes all state |
| split_mode | input | 1 | 0: one request line for packed words; 1: separate left/right lines |
| wr_valid | input | 1 | Write strobe from the DMA engine |
| wr_data | input | 32 | Write data (packed word, or sample in bits 15:0) |
| ld_req | input | 1 | Serializer asks for the next entry |
| underrun_clr | input | 1 | Write-one-to-clear for the underrun flag |
| ld_data | output | 32 | Word handed to the shift register |
| req_l | output | 1 | Left (or packed) DMA write request |
| req_r | output | 1 | Right DMA write request |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default values: a depth of 8 entries, 32-bit words and 16-bit samples. At this depth a fill takes eight writes and a drain takes eight loads, so full and empty transitions, pointer wraparound and the underrun case all come up many times in a short run. Directed phases cover each mode and each boundary. A long pseudo-random phase then mixes writes, loads, flushes and flag clears in both modes, with a queue-based model checked on every cycle.

// File: rtl/afd_pkg.sv
package afd_pkg;
    typedef enum logic {
        REQ_PACKED = 1'b0,
        REQ_SPLIT  = 1'b1
    } req_mode_e;
endpackage

// File: rtl/afd_store.sv
module afd_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/afd_pack.sv
module afd_pack
    import afd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              split_mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              accept,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              exp_right_nxt
);
    typedef struct packed {
        logic [HALF_W-1:0] hold;
        logic              exp_right;
    } pack_t;

    pack_t st_q, st_d;
    logic  is_split;

    always_comb begin
        is_split  = (req_mode_e'(split_mode) == REQ_SPLIT);
        st_d      = st_q;
        push      = 1'b0;
        push_data = wr_data;
        if (!enable || !is_split) begin
            st_d.exp_right = 1'b0;
            push           = enable && wr_valid && accept;
        end else begin
            push_data = {st_q.hold, wr_data[HALF_W-1:0]};
            if (wr_valid && accept) begin
                if (!st_q.exp_right) begin
                    st_d.hold      = wr_data[HALF_W-1:0];
                    st_d.exp_right = 1'b1;
                end else begin
                    push           = 1'b1;
                    st_d.exp_right = 1'b0;
                end
            end
        end
        exp_right_nxt = st_d.exp_right;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/afd_ctrl.sv
module afd_ctrl
    import afd_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              split_mode,
    input  logic              push,
    input  logic              exp_right_nxt,
    input  logic              ld_req,
    input  logic              underrun_clr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [PW-1:0]     wptr,
    output logic [PW-1:0]     rptr,
    output logic              full,
    output logic [CW-1:0]     cnt,
    output logic              started,
    output logic              req_l,
    output logic              req_r,
    output logic [DATA_W-1:0] ld_data,
    output logic              underrun
);
    typedef struct packed {
        logic [PW-1:0]     wptr;
        logic [PW-1:0]     rptr;
        logic [CW-1:0]     cnt;
        logic              started;
        logic              req_l;
        logic              req_r;
        logic              underrun;
        logic [DATA_W-1:0] ld_data;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  pop, starve, nxt_full, is_split;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        is_split = (req_mode_e'(split_mode) == REQ_SPLIT);
        pop      = ld_req && st_q.started && (st_q.cnt != '0);
        starve   = ld_req && st_q.started && (st_q.cnt == '0);
        nxt_full = 1'b0;
        st_d.underrun = starve || (st_q.underrun && !underrun_clr);
        if (!enable) begin
            st_d.wptr    = '0;
            st_d.rptr    = '0;
            st_d.cnt     = '0;
            st_d.started = 1'b0;
            st_d.req_l   = 1'b0;
            st_d.req_r   = 1'b0;
            st_d.ld_data = '0;
        end else begin
            if (push) st_d.wptr = wrap_inc(st_q.wptr);
            if (pop)  st_d.rptr = wrap_inc(st_q.rptr);
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
            nxt_full = (st_d.cnt == CW'(DEPTH));
            st_d.started = st_q.started || nxt_full;
            if (pop)         st_d.ld_data = rd_data;
            else if (ld_req) st_d.ld_data = '0;
            st_d.req_l = !nxt_full && (!is_split || !exp_right_nxt);
            st_d.req_r = !nxt_full && is_split && exp_right_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wptr     = st_q.wptr;
    assign rptr     = st_q.rptr;
    assign cnt      = st_q.cnt;
    assign full     = (st_q.cnt == CW'(DEPTH));
    assign started  = st_q.started;
    assign req_l    = st_q.req_l;
    assign req_r    = st_q.req_r;
    assign ld_data  = st_q.ld_data;
    assign underrun = st_q.underrun;
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              split_mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_req,
    input  logic              underrun_clr,
    output logic [DATA_W-1:0] ld_data,
    output logic              req_l,
    output logic              req_r,
    output logic              underrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic              push, full_w, exp_nxt, started_w;
    logic [DATA_W-1:0] push_data, rd_data;
    logic [PW-1:0]     wptr, rptr;
    logic [CW-1:0]     cnt_w;

    afd_pack #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .enable(enable), .split_mode(split_mode),
        .wr_valid(wr_valid), .wr_data(wr_data), .accept(!full_w),
        .push(push), .push_data(push_data), .exp_right_nxt(exp_nxt)
    );

    afd_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(push), .waddr(wptr), .wdata(push_data),
        .raddr(rptr), .rdata(rd_data)
    );

    afd_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .split_mode(split_mode),
        .push(push), .exp_right_nxt(exp_nxt), .ld_req(ld_req),
        .underrun_clr(underrun_clr), .rd_data(rd_data),
        .wptr(wptr), .rptr(rptr), .full(full_w), .cnt(cnt_w),
        .started(started_w), .req_l(req_l), .req_r(req_r),
        .ld_data(ld_data), .underrun(underrun)
    );
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              split_mode,
    input logic              ld_req,
    input logic              underrun_clr,
    input logic              req_l,
    input logic              req_r,
    input logic              underrun,
    input logic [DATA_W-1:0] ld_data,
    input logic [CW-1:0]     cnt,
    input logic              started
);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    p_packed_no_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |=> !req_r);

    p_prefill_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && ld_req) |=> (ld_data == '0));

    p_full_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> (!req_l && !req_r));

    p_lines_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_l && req_r));

    p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !underrun_clr) |=> underrun);

    p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!req_l && !req_r && cnt == '0));
endmodule

bind audio_tx_fifo afd_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .split_mode(split_mode),
    .ld_req(ld_req), .underrun_clr(underrun_clr), .req_l(req_l),
    .req_r(req_r), .underrun(underrun), .ld_data(ld_data),
    .cnt(cnt_w), .started(started_w)
);

// File: tb/sim_audio_tx_fifo.sv
module sim_audio_tx_fifo;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, split = 1'b0, wv = 1'b0, lr = 1'b0, clr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] ld_data;
    logic        req_l, req_r, underrun;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    audio_tx_fifo u0 (
        .clk(clk), .rst_n(rst_n), .enable(en), .split_mode(split),
        .wr_valid(wv), .wr_data(wd), .ld_req(lr), .underrun_clr(clr),
        .ld_data(ld_data), .req_l(req_l), .req_r(req_r), .underrun(underrun)
    );

    // Behavioural reference model
    logic [31:0] mq[$];
    logic [31:0] m_ld, m_pop;
    logic [15:0] m_hold;
    bit m_started, m_expr, m_reql, m_reqr, m_und, m_full, m_popd, m_starve;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_ld = '0; m_hold = '0;
            m_started = 0; m_expr = 0; m_reql = 0; m_reqr = 0; m_und = 0;
        end else begin
            m_full   = (mq.size() == DEPTH);
            m_popd   = lr && m_started && (mq.size() > 0);
            m_starve = lr && m_started && (mq.size() == 0);
            m_und    = m_starve || (m_und && !clr);
            if (!en) begin
                mq.delete();
                m_started = 0; m_expr = 0; m_reql = 0; m_reqr = 0; m_ld = '0;
            end else begin
                m_pop = '0;
                if (m_popd) m_pop = mq.pop_front();
                if (wv && !m_full) begin
                    if (!split) begin
                        mq.push_back(wd);
                        m_expr = 0;
                    end else if (!m_expr) begin
                        m_hold = wd[15:0];
                        m_expr = 1;
                    end else begin
                        mq.push_back({m_hold, wd[15:0]});
                        m_expr = 0;
                    end
                end else if (!split) begin
                    m_expr = 0;
                end
                if (m_popd)  m_ld = m_pop;
                else if (lr) m_ld = '0;
                if (mq.size() == DEPTH) m_started = 1;
                m_reql = (mq.size() != DEPTH) && (!split || !m_expr);
                m_reqr = (mq.size() != DEPTH) && split && m_expr;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(req_l === m_reql, "R5 req_l", {31'b0, req_l}, {31'b0, m_reql});
            check(req_r === m_reqr, "R6 req_r", {31'b0, req_r}, {31'b0, m_reqr});
            check(ld_data === m_ld, "R9 ld_data", ld_data, m_ld);
            check(underrun === m_und, "R7 underrun", {31'b0, underrun}, {31'b0, m_und});
        end
    end

    task automatic cyc(input logic e, input logic s, input logic v,
                       input logic [31:0] d, input logic l, input logic c);
        en = e; split = s; wv = v; wd = d; lr = l; clr = c;
        @(negedge clk);
    endtask

    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000 && !done) begin
            done = 1;
            n_checks++; n_errs++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc_cnt);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_l == 0 && req_r == 0 && underrun == 0, "R1 flags", {29'b0, req_l, req_r, underrun}, 0);
        check(ld_data == 0, "R1 ld_data", ld_data, 0);

        // R3: packed mode, enable
        cyc(1, 0, 0, 0, 0, 0);
        check(req_l == 1 && req_r == 0, "R3 req after enable", {30'b0, req_l, req_r}, 32'h2);
        for (int i = 0; i < DEPTH; i++)
            cyc(1, 0, 1, 32'hA000_0000 + i, (i == 3), 0);
        check(req_l == 0, "R5 drop after fill", {31'b0, req_l}, 0);
        check(ld_data == 0 && underrun == 0, "R4 prefill load ignored", ld_data, 0);
        cyc(1, 0, 1, 32'hDEAD_BEEF, 0, 0);          // discarded (R2)
        cyc(1, 0, 0, 0, 1, 0);
        check(ld_data == 32'hA000_0000, "R9 first word", ld_data, 32'hA000_0000);
        check(req_l == 1, "R5 reraise after load", {31'b0, req_l}, 1);
        for (int i = 1; i < DEPTH; i++) begin
            cyc(1, 0, 0, 0, 1, 0);
            check(ld_data == 32'hA000_0000 + i, "R2 order", ld_data, 32'hA000_0000 + i);
        end
        cyc(1, 0, 0, 0, 0, 0);
        check(ld_data == 32'hA000_0007, "R9 hold", ld_data, 32'hA000_0007);
        cyc(1, 0, 0, 0, 1, 0);
        check(ld_data == 0, "R2 discard full write", ld_data, 0);
        check(underrun == 1, "R7 set", {31'b0, underrun}, 1);
        cyc(1, 0, 0, 0, 0, 0);
        check(underrun == 1, "R7 sticky", {31'b0, underrun}, 1);
        cyc(1, 0, 0, 0, 0, 1);
        check(underrun == 0, "R7 cleared", {31'b0, underrun}, 0);

        // R8: flush on disable
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 32'h5500_0000 + i, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        check(req_l == 0 && req_r == 0, "R8 requests low", {30'b0, req_l, req_r}, 0);
        cyc(1, 0, 0, 0, 1, 0);
        check(ld_data == 0 && underrun == 0, "R8 prefill restarted", ld_data, 0);
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 1, 32'hB000_0000 + i, 0, 0);
        cyc(1, 0, 1, 32'hB000_0008, 1, 0);           // load with no push (full)
        check(ld_data == 32'hB000_0000, "R8 old entries gone", ld_data, 32'hB000_0000);
        cyc(1, 0, 1, 32'hB000_0009, 1, 0);           // push and pop together
        check(ld_data == 32'hB000_0001, "R2 push+pop", ld_data, 32'hB000_0001);

        // R6: split mode
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        check(req_l == 1 && req_r == 0, "R6 expect left", {30'b0, req_l, req_r}, 32'h2);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, 1, 1, 32'hFFFF_1100 + i, 0, 0);
            if (i == 0) check(req_l == 0 && req_r == 1, "R6 expect right", {30'b0, req_l, req_r}, 32'h1);
            cyc(1, 1, 1, 32'hEEEE_2200 + i, 0, 0);
        end
        check(req_l == 0 && req_r == 0, "R6 full", {30'b0, req_l, req_r}, 0);
        cyc(1, 1, 0, 0, 1, 0);
        check(ld_data == 32'h1100_2200, "R6 pair packing", ld_data, 32'h1100_2200);

        // Pseudo-random phases in both modes
        for (int ph = 0; ph < 2; ph++) begin
            cyc(0, ph[0], 0, 0, 0, 0);
            for (int k = 0; k < 3000; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(lfsr[5:0] != 0, ph[0], lfsr[7] | lfsr[9], {lfsr, ~lfsr},
                    lfsr[8] & lfsr[11], lfsr[3:0] == 4'hF);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule